// File: doc/BRIEF.md
# Multichannel Conversion Ready Tracker

This block runs a round-robin of conversions over a small set of channels and keeps, per channel, the latest result, a status tag naming the channel that produced it, and a ready bit. Each conversion lasts a programmable number of clock cycles per channel. A cycle counter stands in for the modulator. When it expires, the word on `sample_in` becomes that channel's result. A shared active-low ready output summarises the ready bits under one of two policies. It signals lost data with a fixed-length high pulse whenever an unread result is overwritten.

Software-side logic starts the round with a mode write that carries a continuous flag and a start channel. It clears a channel's ready bit with a one-cycle read strobe. While that channel's data register is being shifted out, it holds the channel's busy flag. A completion that lands while the busy flag is high is discarded, so a result is never changed in the middle of a read.

The sequencer has two states. `ST_IDLE` waits. `ST_CONV` counts the current channel's conversion time and then steps to the next enabled channel. The transitions are named as follows:
- *launch* goes from `ST_IDLE` to `ST_CONV` on a continuous mode write with a non-empty mask.
- *restart* stays in `ST_CONV` on a continuous mode write, and reloads the channel and counter.
- *halt* goes from `ST_CONV` to `ST_IDLE` on a mode write that is not continuous or has an empty mask.
- *starve* goes from `ST_CONV` to `ST_IDLE` when the enable mask becomes empty.

Top module: `conv_ready_tracker`

## Requirements
- R1: A mode write clears every ready bit and any lost-data pulse. In the cycle after the write edge `rdy_bits` is 0 and `rdy_n` is 1.
- R2: After a continuous mode write, the first conversion runs on `mode_chan` if that channel is enabled. Otherwise it runs on the next enabled channel above it, wrapping. A start address at or above the channel count counts as channel 0. The first completion takes effect on the T-th rising edge after the write edge, where T is that channel's conversion time.
- R3: After each completion the sequencer moves to the next enabled channel in ascending order and wraps around. Disabled channels are skipped. One full round therefore lasts the sum of the enabled channels' conversion times.
- R4: On a completion for channel i, `res_data` slice i takes the `sample_in` value present at that edge. `res_chan` slice i takes the value i, and `rdy_bits[i]` is set. `rd_strobe[i]` clears `rdy_bits[i]` at the next edge. A completion in the same cycle wins over the strobe.
- R5: With `rdy_all` = 0 and no lost-data pulse running, `rdy_n` is 0 exactly when at least one ready bit is set.
- R6: With `rdy_all` = 1 and no pulse running, `rdy_n` is 0 exactly when the mask is non-empty and every enabled channel's ready bit is set.
- R7: A completion on a channel whose ready bit is still set replaces the stored result. It also drives `rdy_n` high for exactly LOST_HIGH cycles (default 163), counted from the edge of that completion.
- R8: A completion on channel i while `rd_busy[i]` is 1 is discarded. The data, the tag and the ready bit stay unchanged, and no lost-data pulse starts.
- R9: After a mode write that is not continuous, or while the mask is empty, no completion occurs. The ready bits and results stay unchanged.
- R10: Reset clears all ready bits, results and tags, and drives `rdy_n` high.
- R11: A programmed conversion time of 0 acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_cont | input | 1 | Continuous command flag carried by the mode write |
| mode_chan | input | CW | Start channel carried by the mode write |
| chan_en | input | NCH | Channel enable mask |
| conv_time | input | NCH*TW | Conversion time per channel in cycles, channel i at bits [i*TW +: TW] |
| rdy_all | input | 1 | Ready policy: 0 any unread, 1 all enabled unread |
| rd_strobe | input | NCH | Per-channel data-read strobe, clears the ready bit |
| rd_busy | input | NCH | Per-channel read-in-progress flag |
| sample_in | input | DW | Conversion result captured at a completion |
| rdy_n | output | 1 | Shared active-low ready output |
| rdy_bits | output | NCH | Per-channel ready bits |
| res_data | output | NCH*DW | Stored results, channel i at bits [i*DW +: DW] |
| res_chan | output | NCH*CW | Stored status tags (channel number), channel i at bits [i*CW +: CW] |

## Verification
Take a mode write sampled at edge E. Each completion after it falls on edge E plus the running sum of conversion times along the enabled-channel order. Results, tags and ready bits are registered at that edge and show at the next falling edge. The bench drives a distinct `sample_in` value at every falling edge and numbers those edges, so it can compute each expected result from the completion edge alone. It then samples one falling edge later. Read strobes, busy flags and mode writes are driven at falling edges and take effect at the next rising edge. The lost-data pulse is checked on its last high cycle and on its first low cycle, LOST_HIGH and LOST_HIGH+1 falling edges after the overwrite.

// File: rtl/crt_pkg.sv
package crt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;
endpackage

// File: rtl/crt_seq.sv
module crt_seq
    import crt_pkg::*;
#(
    parameter int NCH = 3,
    parameter int TW  = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_cont,
    input  logic [CW-1:0]     mode_chan,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*TW-1:0] conv_time,
    output logic              conv_done,
    output logic [CW-1:0]     cur_chan
);
    seq_state_e state_q, state_d;
    logic [TW-1:0] cnt_q;
    logic [CW-1:0] cur_q;
    logic [CW-1:0] start_base, start_sel;
    logic [TW-1:0] tsel;
    logic          hit;
    logic          go_cont;

    // next enabled channel strictly after 'from', wrapping; 'from' itself last
    function automatic logic [CW-1:0] next_en(input logic [CW-1:0] from,
                                              input logic [NCH-1:0] en);
        logic [CW-1:0] res;
        int            idx;
        res = from;
        for (int j = NCH; j >= 1; j--) begin
            idx = int'(from) + j;
            if (idx >= NCH) idx = idx - NCH;
            if (idx < NCH && en[idx]) res = CW'(idx);
        end
        return res;
    endfunction

    always_comb begin
        start_base = (int'(mode_chan) < NCH) ? mode_chan : '0;
        start_sel  = chan_en[start_base] ? start_base : next_en(start_base, chan_en);
        go_cont    = mode_wr && mode_cont && (chan_en != '0);
        tsel       = conv_time[int'(cur_q)*TW +: TW];
        hit        = ({1'b0, cnt_q} + (TW+1)'(1)) >= {1'b0, tsel};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_cont) state_d = ST_CONV;              // launch
            ST_CONV: begin
                if (mode_wr && !go_cont)   state_d = ST_IDLE;     // halt
                else if (chan_en == '0)    state_d = ST_IDLE;     // starve
                else                       state_d = ST_CONV;     // run / restart
            end
        endcase
    end

    // channel pointer and conversion counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= '0;
        end else if (mode_wr) begin
            cnt_q <= '0;
            cur_q <= start_sel;
        end else if (state_q == ST_CONV) begin
            if (hit) begin
                cnt_q <= '0;
                cur_q <= next_en(cur_q, chan_en);
            end else begin
                cnt_q <= cnt_q + TW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        conv_done = (state_q == ST_CONV) && hit && !mode_wr;
        cur_chan  = cur_q;
    end
endmodule

// File: rtl/crt_chan.sv
module crt_chan #(
    parameter int DW  = 8,
    parameter int CW  = 2,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          done_here,
    input  logic          rd_strobe,
    input  logic          rd_busy,
    input  logic [DW-1:0] sample,
    output logic          rdy,
    output logic [DW-1:0] data,
    output logic [CW-1:0] tag,
    output logic          lost
);
    localparam logic [CW-1:0] MY_TAG = CW'(IDX);
    logic accept;

    always_comb begin
        accept = done_here && !rd_busy && !clr;
        lost   = accept && rdy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy  <= 1'b0;
            data <= '0;
            tag  <= '0;
        end else begin
            if (accept) begin
                data <= sample;
                tag  <= MY_TAG;
            end
            if (clr)            rdy <= 1'b0;
            else if (accept)    rdy <= 1'b1;
            else if (rd_strobe) rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/crt_pin.sv
module crt_pin #(
    parameter int NCH       = 3,
    parameter int LOST_HIGH = 163,
    localparam int LCW      = $clog2(LOST_HIGH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           lost_any,
    input  logic           rdy_all,
    input  logic [NCH-1:0] chan_en,
    input  logic [NCH-1:0] rdy_bits,
    output logic           rdy_n
);
    logic [LCW-1:0] hold_q;
    logic           any_ok, all_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hold_q <= '0;
        else if (clr)           hold_q <= '0;
        else if (lost_any)      hold_q <= LCW'(LOST_HIGH);
        else if (hold_q != '0)  hold_q <= hold_q - LCW'(1);
    end

    always_comb begin
        any_ok = (rdy_bits != '0);
        all_ok = (chan_en != '0) && ((rdy_bits | ~chan_en) == '1);
        rdy_n  = !((rdy_all ? all_ok : any_ok) && (hold_q == '0));
    end
endmodule

// File: rtl/conv_ready_tracker.sv
module conv_ready_tracker #(
    parameter int NCH       = 3,
    parameter int DW        = 8,
    parameter int TW        = 8,
    parameter int LOST_HIGH = 163,
    localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_cont,
    input  logic [CW-1:0]     mode_chan,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*TW-1:0] conv_time,
    input  logic              rdy_all,
    input  logic [NCH-1:0]    rd_strobe,
    input  logic [NCH-1:0]    rd_busy,
    input  logic [DW-1:0]     sample_in,
    output logic              rdy_n,
    output logic [NCH-1:0]    rdy_bits,
    output logic [NCH*DW-1:0] res_data,
    output logic [NCH*CW-1:0] res_chan
);
    logic           conv_done;
    logic [CW-1:0]  cur_chan;
    logic [NCH-1:0] lost_vec;
    logic           lost_any;

    crt_seq #(.NCH(NCH), .TW(TW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_cont(mode_cont),
        .mode_chan(mode_chan),
        .chan_en  (chan_en),
        .conv_time(conv_time),
        .conv_done(conv_done),
        .cur_chan (cur_chan)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        crt_chan #(.DW(DW), .CW(CW), .IDX(i)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (mode_wr),
            .done_here(conv_done && (cur_chan == CW'(i))),
            .rd_strobe(rd_strobe[i]),
            .rd_busy  (rd_busy[i]),
            .sample   (sample_in),
            .rdy      (rdy_bits[i]),
            .data     (res_data[i*DW +: DW]),
            .tag      (res_chan[i*CW +: CW]),
            .lost     (lost_vec[i])
        );
    end

    assign lost_any = |lost_vec;

    crt_pin #(.NCH(NCH), .LOST_HIGH(LOST_HIGH)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_wr),
        .lost_any(lost_any),
        .rdy_all (rdy_all),
        .chan_en (chan_en),
        .rdy_bits(rdy_bits),
        .rdy_n   (rdy_n)
    );
endmodule

// File: rtl/crt_checks.sv
module crt_checks #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mode_wr,
    input logic           rdy_all,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] rdy_bits,
    input logic           rdy_n,
    input logic           conv_done,
    input logic           lost_any
);
    assert_mode_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (rdy_bits == '0) && rdy_n);

    assert_rise_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdy_bits & ~$past(rdy_bits)) != '0) |-> $past(conv_done));

    assert_none_unread_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_bits == '0) |-> rdy_n);

    assert_all_policy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_all && ((chan_en & ~rdy_bits) != '0)) |-> rdy_n);

    assert_lost_forces_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost_any |=> rdy_n);

    assert_empty_mask_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == '0) |=> !conv_done);
endmodule

bind conv_ready_tracker crt_checks #(.NCH(NCH)) u_crt_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .rdy_all  (rdy_all),
    .chan_en  (chan_en),
    .rdy_bits (rdy_bits),
    .rdy_n    (rdy_n),
    .conv_done(conv_done),
    .lost_any (lost_any)
);

// File: tb/test_conv_ready_tracker.sv
module test_conv_ready_tracker;
    localparam int NCH = 3;
    localparam int DW  = 8;
    localparam int TW  = 8;
    localparam int CW  = 2;
    localparam int LH  = 163;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_wr = 1'b0;
    logic              mode_cont = 1'b0;
    logic [CW-1:0]     mode_chan = '0;
    logic [NCH-1:0]    chan_en = '0;
    logic [NCH*TW-1:0] conv_time = '0;
    logic              rdy_all = 1'b0;
    logic [NCH-1:0]    rd_strobe = '0;
    logic [NCH-1:0]    rd_busy = '0;
    logic [DW-1:0]     sample_in = '0;
    logic              rdy_n;
    logic [NCH-1:0]    rdy_bits;
    logic [NCH*DW-1:0] res_data;
    logic [NCH*CW-1:0] res_chan;

    int checks = 0;
    int errors = 0;
    int ncnt   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    conv_ready_tracker i_conv_ready_tracker (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cont(mode_cont),
        .mode_chan(mode_chan), .chan_en(chan_en), .conv_time(conv_time),
        .rdy_all(rdy_all), .rd_strobe(rd_strobe), .rd_busy(rd_busy),
        .sample_in(sample_in), .rdy_n(rdy_n), .rdy_bits(rdy_bits),
        .res_data(res_data), .res_chan(res_chan)
    );

    function automatic logic [7:0] f(input int n);
        return 8'((n * 37 + 11) & 255);
    endfunction

    task automatic step();
        @(negedge clk);
        ncnt++;
        sample_in = f(ncnt);
    endtask

    task automatic wait_to(input int n);
        while (ncnt < n) step();
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns the negedge index at which the write was driven
    task automatic mode_write(input bit cont, input int ch, output int n0);
        mode_wr   = 1'b1;
        mode_cont = cont;
        mode_chan = CW'(ch);
        n0 = ncnt;
        step();
        mode_wr = 1'b0;
    endtask

    function automatic int nxt(input int from, input int mask);
        for (int j = 1; j <= NCH; j++) begin
            if (mask[(from + j) % NCH]) return (from + j) % NCH;
        end
        return from;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        int t[NCH];
        step(); step();
        // R10 reset state
        chk("R10 rdy_n", int'(rdy_n), 1);
        chk("R10 rdy_bits", int'(rdy_bits), 0);
        chk("R10 res_data", int'(res_data), 0);
        chk("R10 res_chan", int'(res_chan), 0);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 R5 R6 R7 sweep over masks, start channels, policies
        for (int mask = 1; mask < 8; mask++) begin
            for (int st = 0; st < NCH; st++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    int k, acc, visited, cnt, first;
                    for (int i = 0; i < NCH; i++) begin
                        t[i] = 2 + ((i + mask + st) % 3);
                        conv_time[i*TW +: TW] = TW'(t[i]);
                    end
                    chan_en = NCH'(mask);
                    rdy_all = pol[0];
                    mode_write(1'b1, st, n0);
                    chk("R1 bits cleared", int'(rdy_bits), 0);
                    first = mask[st] ? st : nxt(st, mask);
                    k = first; acc = 0; visited = 0;
                    cnt = $countones(NCH'(mask));
                    for (int c = 0; c <= cnt; c++) begin
                        acc += t[k];
                        wait_to(n0 + acc + 1);
                        visited |= (1 << k);
                        chk("R3 ready pattern", int'(rdy_bits), visited);
                        chk("R4 data", int'(res_data[k*DW +: DW]), int'(f(n0 + acc)));
                        chk("R4 tag", int'(res_chan[k*CW +: CW]), k);
                        if (c == 0)
                            chk(pol ? "R6 first" : "R5 first", int'(rdy_n),
                                (pol && cnt > 1) ? 1 : 0);
                        else if (c == cnt - 1)
                            chk(pol ? "R6 round done" : "R5 round done", int'(rdy_n), 0);
                        if (c == cnt)
                            chk("R7 wrap overwrite high", int'(rdy_n), 1);
                        k = nxt(k, mask);
                    end
                end
            end
        end
        rdy_all = 1'b0;

        // R4 read strobe clears; completion beats strobe
        conv_time = '0;
        conv_time[0*TW +: TW] = 3;
        conv_time[1*TW +: TW] = 4;
        chan_en = 3'b011;
        mode_write(1'b1, 0, n0);
        wait_to(n0 + 4);
        chk("R4 ch0 set", int'(rdy_bits), 1);
        rd_strobe = 3'b001;
        step();
        rd_strobe = '0;
        chk("R4 read clears", int'(rdy_bits), 0);
        chk("R5 none unread", int'(rdy_n), 1);
        wait_to(n0 + 8);
        chk("R4 ch1 set", int'(rdy_bits), 2);
        chk("R5 one unread", int'(rdy_n), 0);
        chk("R4 ch1 data", int'(res_data[1*DW +: DW]), int'(f(n0 + 7)));
        wait_to(n0 + 10);
        rd_strobe = 3'b001;
        step();
        rd_strobe = '0;
        chk("R4 completion wins", int'(rdy_bits), 3);

        // R8 busy read drops completion
        conv_time[0*TW +: TW] = 6;
        chan_en = 3'b001;
        mode_write(1'b1, 0, n0);
        wait_to(n0 + 7);
        chk("R8 first set", int'(rdy_bits), 1);
        rd_busy = 3'b001;
        wait_to(n0 + 13);
        chk("R8 data kept", int'(res_data[0 +: DW]), int'(f(n0 + 6)));
        chk("R8 bit kept", int'(rdy_bits), 1);
        chk("R8 no pulse", int'(rdy_n), 0);
        rd_busy = '0;
        wait_to(n0 + 19);
        chk("R8 resumes", int'(res_data[0 +: DW]), int'(f(n0 + 18)));

        // R11 zero conversion time
        conv_time[2*TW +: TW] = 0;
        chan_en = 3'b100;
        mode_write(1'b1, 2, n0);
        wait_to(n0 + 2);
        chk("R11 first", int'(res_data[2*DW +: DW]), int'(f(n0 + 1)));
        step();
        chk("R11 second", int'(res_data[2*DW +: DW]), int'(f(n0 + 2)));

        // R7 pulse length
        conv_time[0*TW +: TW] = 200;
        chan_en = 3'b001;
        mode_write(1'b1, 0, n0);
        wait_to(n0 + 201);
        chk("R7 first low", int'(rdy_n), 0);
        wait_to(n0 + 401);
        chk("R7 overwrite data", int'(res_data[0 +: DW]), int'(f(n0 + 400)));
        chk("R7 pulse start", int'(rdy_n), 1);
        wait_to(n0 + 400 + LH);
        chk("R7 last high", int'(rdy_n), 1);
        step();
        chk("R7 low after pulse", int'(rdy_n), 0);
        wait_to(n0 + 602);
        chk("R7 second pulse", int'(rdy_n), 1);

        // R1 mode write during pulse, R9 no completions afterwards
        begin
            int m0;
            mode_write(1'b0, 0, m0);
            chk("R1 bits zero", int'(rdy_bits), 0);
            chk("R1 pin high", int'(rdy_n), 1);
            wait_to(m0 + 300);
            chk("R9 idle bits", int'(rdy_bits), 0);
            chk("R9 idle data", int'(res_data[0 +: DW]), int'(f(n0 + 600)));
            chan_en = '0;
            mode_write(1'b1, 0, m0);
            wait_to(m0 + 40);
            chk("R9 empty mask bits", int'(rdy_bits), 0);
            chk("R9 empty mask pin", int'(rdy_n), 1);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule